// File: doc/BRIEF.md
# Read-Triggered Sampling Converter Controller

This block is the register-side controller for a multiplexed analog sampling converter. A host reaches it over a small register bus (address, write strobe, read strobe, write data, registered read data). Reading the result register starts a conversion as a side effect. That read returns whatever the register held just before, so the host gets the previous sample and clears the ready flag at the same time. The host then polls the same register until bit 31 comes back set. Polling reads made while a conversion is in flight do not restart it.

A clock-select bit picks how much the module clock is divided: by 16 (slow, the reset choice) or by 4 (fast). Conversion and settling times are counted in ticks of that divided clock. A sample taken from the converter input is clamped to ±25000 and stored as a 16-bit two's-complement value. The analog input switch word can only be changed by the one bus access that immediately follows a key write of 0xAA to the lock register. It accepts only the eight legal channel words. An accepted switch change starts a settling interval, and any conversion asked for, or already running, is held until settling ends.

Top module: `adc_ctrl`

## Requirements
- R1: After reset the result register reads 0 (ready flag bit 31 clear), the switch register (offset 0x18) reads 0, the lock register (offset 0x20, bit 0 = unlocked) reads 0, the config register (offset 0x00, bit 0 = fast divider) reads 0, and mux_sel_o is 0.
- R2: A write to the switch register while locked leaves the switch register and mux_sel_o unchanged.
- R3: Writing 32'hAA to the lock register unlocks it. A switch write of a legal word as the very next access is stored, and appears on mux_sel_o one cycle later.
- R4: Any bus access after the key, other than a further key write, relocks the block, so a switch write that follows such an access is ignored.
- R5: Only the words 0x608, 0x680, 0x640, 0x620, 0x610, 0x601, 0x602 and 0x604 (upper bits zero) are stored. An unlocked write of any other word is ignored and still uses up the unlock.
- R6: A read of the result register (offset 0x08) while no conversion is running or pending returns the register's previous contents and starts a conversion. A read in the next cycle shows the same sample with bit 31 clear.
- R7: A conversion ends exactly CONV_TICKS × D clock edges after the starting read's edge, where D is 16 when config bit 0 is 0 and 4 when it is 1. Once it ends, the result reads {1'b1, 15'b0, sample[15:0]}.
- R8: Reads of the result register during a conversion return bit 31 = 0 and do not change when that conversion ends.
- R9: Captured samples are clamped to the range -25000..+25000 before storage.
- R10: An accepted switch write starts a settling interval of SETTLE_TICKS × D edges. A conversion triggered during settling ends (SETTLE_TICKS + CONV_TICKS) × D edges after the switch write's edge.
- R11: An accepted switch write during a conversion abandons it. That conversion is queued again and ends (SETTLE_TICKS + CONV_TICKS) × D edges after the switch write's edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte offset |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after re_i |
| sample_i | input | SAMPLE_W | Signed raw converter output |
| mux_sel_o | output | 12 | Current analog switch word |

## Verification
Some rules can be watched on every cycle, and the assertions do that. They check that the switch word changes only after an unlocked switch write and that it never holds an illegal word. They check that the lock closes after any non-key access and that a stored sample never leaves the clamp range. They also check that settling and conversion never overlap, and that the ready flag rises only at the end of a conversion and falls on a starting read. Exact latencies can only be shown by the directed scenarios: ready appearing on the predicted edge for each divider, the added delay when a switch write comes first or arrives mid-conversion, and polling reads that leave the timing alone.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int unsigned OFF_CFG    = 32'h00;
  localparam int unsigned OFF_RESULT = 32'h08;
  localparam int unsigned OFF_SWITCH = 32'h18;
  localparam int unsigned OFF_LOCK   = 32'h20;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_00AA;
  localparam int SW_W   = 12;
  localparam int NUM_CH = 8;

  function automatic logic [SW_W-1:0] chan_word(int unsigned idx);
    case (idx)
      0: return 12'h608;
      1: return 12'h680;
      2: return 12'h640;
      3: return 12'h620;
      4: return 12'h610;
      5: return 12'h601;
      6: return 12'h602;
      7: return 12'h604;
      default: return '0;
    endcase
  endfunction

  function automatic logic sw_legal(logic [31:0] w);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (w == {20'h0, chan_word(i)}) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int DIV_SLOW = 16,
  parameter int DIV_FAST = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(DIV_SLOW);

  logic [CNT_W-1:0] cnt_q, limit;

  assign limit  = fast_i ? CNT_W'(DIV_FAST - 1) : CNT_W'(DIV_SLOW - 1);
  assign tick_o = (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q >= limit)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_timer.sv
module adc_timer #(
  parameter int LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clear_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= CNT_W'(LEN);
    else if (clear_i)          cnt_q <= '0;
    else if (tick_i && busy_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/adc_lock.sv
module adc_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic access_i,
  input  logic key_i,
  output logic open_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       open_o <= 1'b0;
    else if (access_i) open_o <= key_i;
  end
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int SAMPLE_W     = 18,
  parameter int DIV_SLOW     = 16,
  parameter int DIV_FAST     = 4,
  parameter int CONV_TICKS   = 6,
  parameter int SETTLE_TICKS = 10,
  parameter int LIMIT        = 25000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SW_W-1:0]     mux_sel_o
);
  localparam int EXT_W = 32 - SAMPLE_W;

  logic hit_cfg, hit_res, hit_sw, hit_lock;
  logic key_wr, sw_take, rd_res, trig;
  logic lock_open, fast_q, pend_q;
  logic [SW_W-1:0] sw_q;
  logic [31:0] result_q;
  logic tick, presc_restart;
  logic settle_busy, settle_done, conv_busy, conv_done;
  logic conv_load, conv_end;
  logic signed [31:0] samp_ext, samp_clip;

  assign hit_cfg  = (addr_i == ADDR_W'(OFF_CFG));
  assign hit_res  = (addr_i == ADDR_W'(OFF_RESULT));
  assign hit_sw   = (addr_i == ADDR_W'(OFF_SWITCH));
  assign hit_lock = (addr_i == ADDR_W'(OFF_LOCK));

  assign key_wr  = we_i && hit_lock && (wdata_i == UNLOCK_KEY);
  assign sw_take = we_i && hit_sw && lock_open && sw_legal(wdata_i);
  assign rd_res  = re_i && !we_i && hit_res;
  assign trig    = rd_res && !conv_busy && !pend_q;

  // start now if not settling; else hand off when settling ends
  assign conv_load = !sw_take &&
                     ((trig && !settle_busy) || (settle_done && (pend_q || trig)));
  assign conv_end  = conv_done && !sw_take;
  assign presc_restart = sw_take || (trig && !settle_busy);

  adc_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .access_i (we_i || re_i),
    .key_i    (key_wr),
    .open_o   (lock_open)
  );

  adc_prescaler #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fast_i    (fast_q),
    .restart_i (presc_restart),
    .tick_o    (tick)
  );

  adc_timer #(.LEN(SETTLE_TICKS)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sw_take),
    .clear_i (1'b0),
    .tick_i  (tick),
    .busy_o  (settle_busy),
    .done_o  (settle_done)
  );

  adc_timer #(.LEN(CONV_TICKS)) u_conv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (conv_load),
    .clear_i (sw_take),
    .tick_i  (tick),
    .busy_o  (conv_busy),
    .done_o  (conv_done)
  );

  always_comb begin
    samp_ext = {{EXT_W{sample_i[SAMPLE_W-1]}}, sample_i};
    if (samp_ext > LIMIT)       samp_clip = LIMIT;
    else if (samp_ext < -LIMIT) samp_clip = -LIMIT;
    else                        samp_clip = samp_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= '0;
      fast_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (sw_take) sw_q <= wdata_i[SW_W-1:0];
      if (we_i && hit_cfg) fast_q <= wdata_i[0];
      if (sw_take)                   pend_q <= pend_q || conv_busy || trig;
      else if (settle_done)          pend_q <= 1'b0;
      else if (trig && settle_busy)  pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       result_q <= '0;
    else if (conv_end) result_q <= {1'b1, 15'h0, samp_clip[15:0]};
    else if (trig)     result_q[31] <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) begin
      if (hit_cfg)       rdata_o <= {31'h0, fast_q};
      else if (hit_res)  rdata_o <= result_q;
      else if (hit_sw)   rdata_o <= {20'h0, sw_q};
      else if (hit_lock) rdata_o <= {31'h0, lock_open};
      else               rdata_o <= '0;
    end
  end

  assign mux_sel_o = sw_q;
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk
  import adc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LIMIT  = 25000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [31:0]       wdata_i,
  input logic [SW_W-1:0]   sw_q,
  input logic              lock_open,
  input logic              ready_q,
  input logic [15:0]       sample_q,
  input logic              settle_busy,
  input logic              conv_busy
);
  AST_LOCK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sw_q) |-> $past(we_i && addr_i == ADDR_W'(OFF_SWITCH) && lock_open)); // R2
  AST_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((we_i || re_i) && !(we_i && addr_i == ADDR_W'(OFF_LOCK) && wdata_i == UNLOCK_KEY))
    |=> !lock_open); // R4
  AST_SW_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_q == '0) || sw_legal({20'h0, sw_q})); // R5
  AST_READY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !we_i && addr_i == ADDR_W'(OFF_RESULT) && ready_q) |=> !ready_q); // R6
  AST_READY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> $past(conv_busy)); // R7
  AST_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(sample_q) <= LIMIT) && ($signed(sample_q) >= -LIMIT)); // R9
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(settle_busy && conv_busy)); // R10
endmodule

bind adc_ctrl adc_ctrl_chk #(.ADDR_W(ADDR_W), .LIMIT(LIMIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .re_i        (re_i),
  .wdata_i     (wdata_i),
  .sw_q        (sw_q),
  .lock_open   (lock_open),
  .ready_q     (result_q[31]),
  .sample_q    (result_q[15:0]),
  .settle_busy (settle_busy),
  .conv_busy   (conv_busy)
);

// File: tb/test_adc_ctrl.sv
module test_adc_ctrl;
  localparam int ADDR_W = 8;
  localparam int SAMPLE_W = 18;
  localparam int DS = 16, DF = 4;
  localparam int CONV = 6, SETTLE = 10;
  localparam logic [7:0] A_CFG = 8'h00, A_RES = 8'h08, A_SW = 8'h18, A_LOCK = 8'h20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [SAMPLE_W-1:0] sample = '0;
  logic [11:0] mux_sel;
  int tests = 0, fails = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  adc_ctrl #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W), .DIV_SLOW(DS), .DIV_FAST(DF),
             .CONV_TICKS(CONV), .SETTLE_TICKS(SETTLE), .LIMIT(25000)) i_adc_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .sample_i(sample), .mux_sel_o(mux_sel)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // each op: drive at negedge, act on next posedge, end at following negedge
  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    @(posedge clk); @(negedge clk);
    re = 1'b0; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] res_word(logic rdy, logic [15:0] s);
    return {rdy, 15'h0, s};
  endfunction

  task automatic t_reset;
    bus_read(A_CFG, rd);  check("R1 cfg", rd, 32'h0);
    bus_read(A_SW, rd);   check("R1 switch", rd, 32'h0);
    bus_read(A_LOCK, rd); check("R1 lock", rd, 32'h0);
    check("R1 mux", {20'h0, mux_sel}, 32'h0);
    bus_read(A_RES, rd);  check("R1 result", rd, 32'h0);
    idle(400);
  endtask

  task automatic t_locked;
    bus_write(A_SW, 32'h680);
    bus_read(A_SW, rd); check("R2 locked write", rd, 32'h0);
    check("R2 mux", {20'h0, mux_sel}, 32'h0);
  endtask

  task automatic t_unlock;
    bus_write(A_LOCK, 32'hAA);
    bus_read(A_LOCK, rd); check("R3 lock open", rd, 32'h1);
    bus_write(A_SW, 32'h680);
    bus_read(A_SW, rd); check("R4 read relocks", rd, 32'h0);
    bus_write(A_LOCK, 32'hAA);
    bus_write(A_SW, 32'h680);
    check("R3 mux", {20'h0, mux_sel}, 32'h680);
    bus_read(A_SW, rd); check("R3 switch", rd, 32'h680);
    bus_write(A_SW, 32'h640);
    bus_read(A_SW, rd); check("R2 relocked after use", rd, 32'h680);
    idle(400);
  endtask

  task automatic t_relock;
    bus_write(A_LOCK, 32'hAA);
    bus_read(A_CFG, rd);
    bus_write(A_SW, 32'h640);
    bus_read(A_SW, rd); check("R4 other access relocks", rd, 32'h680);
    bus_write(A_LOCK, 32'hAA);
    bus_write(A_LOCK, 32'h55);
    bus_write(A_SW, 32'h640);
    bus_read(A_SW, rd); check("R4 bad key relocks", rd, 32'h680);
  endtask

  task automatic t_illegal;
    bus_write(A_LOCK, 32'hAA);
    bus_write(A_SW, 32'h123);
    bus_read(A_SW, rd); check("R5 illegal word", rd, 32'h680);
    bus_write(A_LOCK, 32'hAA);
    bus_write(A_SW, 32'h123);
    bus_write(A_SW, 32'h640);
    bus_read(A_SW, rd); check("R5 unlock consumed", rd, 32'h680);
    bus_write(A_LOCK, 32'hAA);
    bus_write(A_SW, 32'h1608);
    check("R5 upper bits", {20'h0, mux_sel}, 32'h680);
  endtask

  task automatic t_timing(logic fast, logic [15:0] s);
    int n;
    n = CONV * (fast ? DF : DS);
    bus_write(A_CFG, {31'h0, fast});
    bus_read(A_CFG, rd); check("R7 cfg", rd, {31'h0, fast});
    sample = SAMPLE_W'($signed(s));
    idle(400);
    bus_read(A_RES, rd);                 // start at E0
    idle(n / 2 - 1);
    bus_read(A_RES, rd);                 // E0 + n/2
    check("R8 mid poll", {rd[31], 31'h0}, 32'h0);
    idle(n - n / 2 - 1);
    bus_read(A_RES, rd);                 // E0 + n
    check("R7 not before end", {rd[31], 31'h0}, 32'h0);
    bus_read(A_RES, rd);                 // E0 + n + 1
    check("R7 ready at end", rd, res_word(1'b1, s));
    bus_read(A_RES, rd);
    check("R6 flag cleared", rd, res_word(1'b0, s));
    idle(400);
  endtask

  task automatic t_clamp(int v, logic [15:0] exp);
    sample = SAMPLE_W'(v);
    idle(400);
    bus_read(A_RES, rd);
    idle(400);
    bus_read(A_RES, rd);
    check("R9 clamp", rd, res_word(1'b1, exp));
  endtask

  task automatic t_settle;
    int n;
    n = (SETTLE + CONV) * DF;
    bus_write(A_CFG, 32'h1);
    sample = SAMPLE_W'(777);
    idle(400);
    bus_write(A_LOCK, 32'hAA);
    bus_write(A_SW, 32'h620);            // Ew
    bus_read(A_RES, rd);                 // Ew+1 trigger while settling
    idle(n - 2);
    bus_read(A_RES, rd);                 // Ew+n
    check("R10 waits for settle", {rd[31], 31'h0}, 32'h0);
    bus_read(A_RES, rd);                 // Ew+n+1
    check("R10 ready after settle", rd, res_word(1'b1, 16'd777));
    check("R10 mux", {20'h0, mux_sel}, 32'h620);
    idle(400);
  endtask

  task automatic t_abort;
    int n;
    n = (SETTLE + CONV) * DF;
    bus_write(A_CFG, 32'h1);
    sample = SAMPLE_W'(-321);
    idle(400);
    bus_read(A_RES, rd);                 // E0
    idle(10);
    bus_write(A_LOCK, 32'hAA);
    bus_write(A_SW, 32'h604);            // Ew = E0+12
    idle(29);
    bus_read(A_RES, rd);                 // Ew+30
    check("R11 aborted conv", {rd[31], 31'h0}, 32'h0);
    idle(n - 31);
    bus_read(A_RES, rd);                 // Ew+n
    check("R11 not before end", {rd[31], 31'h0}, 32'h0);
    bus_read(A_RES, rd);                 // Ew+n+1
    check("R11 requeued conv", rd, res_word(1'b1, 16'hFEBF));
    idle(400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlock();
    t_relock();
    t_illegal();
    t_timing(1'b0, 16'd1234);
    t_timing(1'b1, 16'hF000);
    t_clamp(30000, 16'd25000);
    t_clamp(-40000, 16'h9E58);
    t_clamp(-100, 16'hFF9C);
    t_settle();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule